// File: doc/BRIEF.md
# Guaranteed Slot Transmit Controller

This block sends frames during the contention-free part of a beacon-enabled superframe. It has two transmit buffers, and each one is tied to a guaranteed slot. A host fills a buffer with a framed packet through a byte-wide register and memory port. The host then writes the buffer's control byte with the launch bit set. From that point the buffer is locked.

The controller waits until the superframe is in its contention-free period and the current slot number equals the slot programmed for that buffer. At that point it makes two checks:

- It checks that the frame, plus a fixed overhead, fits into the symbol time left in the slot.
- It checks that the channel is not reported busy.

If both checks pass, it streams the frame bytes out over a valid/ready byte interface. A start strobe comes before the bytes and an end strobe after them. If an acknowledgment was requested, it waits a fixed number of cycles for one. Each timeout without an acknowledgment uses up one retry, and the frame is sent again in the same slot. On completion the controller does three things:

- It writes the outcome flags to a shared status register.
- It writes the number of retries actually used back into the buffer's control byte.
- It raises that buffer's interrupt bit.

The transmit stream follows valid/ready rules. A byte transfers on a clock edge where `tx_valid` and `tx_ready` are both high. While `tx_valid` is high and `tx_ready` is low, `tx_data` holds its value and `tx_valid` stays high. `tx_valid` never depends on `tx_ready`, so the receiver may stall for as long as it likes. Superframe timing, acknowledgment reception and channel-busy detection come in as plain inputs.

Top module: `gts_tx_ctrl`

## Requirements
- R1: Buffer A occupies host addresses 0x100–0x17F and buffer B occupies 0x180–0x1FF. Offset 0 holds the header length m and offset 1 holds the total length L = m+n. Only the bytes at offsets 2 to 2+L−1 are sent, in rising offset order. `tx_start` pulses for one cycle before the first byte is offered. `tx_end` pulses for one cycle after the last byte is accepted.
- R2: The control byte of buffer A is at 0x010 and that of buffer B is at 0x011. The fields are:
  - [7:6] retry limit
  - [5:3] slot number
  - [2] acknowledgment request
  - [1] security flag (stored only)
  - [0] launch
- R3: Writing the control byte with bit 0 set starts that buffer. Bit 0 reads back as 0 from the next cycle on.
- R4: A started buffer transmits only while `cfp_active` is high and `cur_slot` equals its slot field. No strobe or byte appears before that.
- R5: At the slot, if 2·L + FIT_OVH (default 12) exceeds `slot_left`, the frame is not sent. The buffer completes with its no-time flag set: status bit 3 for A, bit 4 for B. Equality still sends.
- R6: At the slot, if `chan_busy` is high, the frame is not sent. The buffer completes with status bit 5 set and its success bit clear.
- R7: With acknowledgment request set, the controller waits ACK_TO cycles after `tx_end`, and `ack_rx` ends the wait with success. Each timeout retransmits while fewer than the retry limit have been used; otherwise the buffer completes as failed. The retry field then reads back the retries used.
- R8: The status register at 0x020 holds the success flags in bit 1 (A) and bit 2 (B). The interrupt register at 0x021 sets bit 1 (A) or bit 2 (B) on completion, and writing 1 to a bit clears it. `irq` is high while any interrupt bit is set.
- R9: When both buffers are started and are due in the same slot, buffer A's frame is sent completely before buffer B's.
- R10: While a buffer is started and not yet complete, host writes to its memory and its control byte are ignored.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` is unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_waddr | input | 9 | Host write address |
| host_wdata | input | 8 | Host write data |
| host_raddr | input | 9 | Host read address |
| host_rdata | output | 8 | Host read data, combinational |
| irq | output | 1 | Interrupt, high while any interrupt bit is set |
| cfp_active | input | 1 | Superframe is in its contention-free period |
| cur_slot | input | 3 | Current guaranteed slot number |
| slot_left | input | 16 | Symbol periods left in the current slot |
| chan_busy | input | 1 | Channel reported busy |
| ack_rx | input | 1 | Acknowledgment received |
| tx_start | output | 1 | One-cycle strobe before a frame |
| tx_valid | output | 1 | Frame byte offered |
| tx_ready | input | 1 | Receiver accepts the byte |
| tx_data | output | 8 | Frame byte |
| tx_end | output | 1 | One-cycle strobe after a frame |

## Verification
The embedded assertions check the following on every cycle:

- A stalled byte stays stable.
- A frame starts only in a cycle that follows the matching slot of the contention-free period.
- The retries used never pass the programmed limit.
- A locked control byte does not move.
- Every completion raises the interrupt.

Some behaviours can only be shown by the bench's scenarios:

- Byte order and content under back-pressure.
- Buffer A winning a shared slot.
- The exact boundary of the time-fit check.
- The retry count written back after one missed acknowledgment.
- The separate no-time and busy-channel flags.

// File: rtl/gts_pkg.sv
package gts_pkg;
  localparam int NBUF      = 2;
  localparam int AW        = 9;
  localparam int BUF_BASE  = 'h100;
  localparam int CTL_ADDR  = 'h010;
  localparam int STAT_ADDR = 'h020;
  localparam int IRQ_ADDR  = 'h021;
  localparam int SELW      = (NBUF > 1) ? $clog2(NBUF) : 1;

  typedef struct packed {
    logic [1:0] retry;
    logic [2:0] slot;
    logic       ackreq;
    logic       sec;
    logic       launch;
  } ctl_t;

  typedef enum logic [2:0] {
    E_IDLE, E_WAIT, E_START, E_SEND, E_END, E_ACKW, E_DONE
  } eng_st_t;
endpackage

// File: rtl/gts_txbuf.sv
module gts_txbuf
  import gts_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int OW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mem_we,
  input  logic [OW-1:0] mem_off,
  input  logic [7:0]    wdata,
  input  logic          ctl_we,
  input  logic [OW-1:0] eng_off,
  output logic [7:0]    eng_byte,
  input  logic [OW-1:0] host_off,
  output logic [7:0]    host_byte,
  output logic [7:0]    len_byte,
  output ctl_t          ctl,
  output logic          busy,
  input  logic          done,
  input  logic [1:0]    done_retry
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (mem_we && !busy) mem[mem_off] <= wdata;
  end

  assign eng_byte  = mem[eng_off];
  assign host_byte = mem[host_off];
  assign len_byte  = mem[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl  <= '0;
      busy <= 1'b0;
    end else if (done) begin
      busy      <= 1'b0;
      ctl.retry <= done_retry;
    end else if (ctl_we && !busy) begin
      ctl  <= ctl_t'({wdata[7:1], 1'b0});
      busy <= wdata[0];
    end
  end

  // R10: a locked control byte only changes at completion
  p_ctl_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> $stable(ctl));
  // R3: launch write locks the buffer and the launch bit reads 0
  p_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && wdata[0] && !busy && !done |=> busy && !ctl.launch);
endmodule

// File: rtl/gts_engine.sv
module gts_engine
  import gts_pkg::*;
#(
  parameter int SW      = 16,
  parameter int ACK_TO  = 54,
  parameter int FIT_OVH = 12,
  localparam int CW = $clog2(ACK_TO + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NBUF-1:0]           pend,
  input  logic [NBUF-1:0][2:0]      slot,
  input  logic [NBUF-1:0]           ackreq,
  input  logic [NBUF-1:0][1:0]      rlim,
  input  logic [NBUF-1:0][7:0]      len_b,
  input  logic [7:0]                rd_byte,
  output logic [7:0]                rd_idx,
  output logic [SELW-1:0]           sel,
  input  logic                      cfp_active,
  input  logic [2:0]                cur_slot,
  input  logic [SW-1:0]             slot_left,
  input  logic                      chan_busy,
  input  logic                      ack_rx,
  output logic                      tx_start,
  output logic                      tx_valid,
  input  logic                      tx_ready,
  output logic [7:0]                tx_data,
  output logic                      tx_end,
  output logic                      done_v,
  output logic                      done_ok,
  output logic                      done_fnt,
  output logic                      done_cca,
  output logic [1:0]                done_used
);
  eng_st_t         st;
  logic [CW-1:0]   cnt;
  logic [NBUF-1:0] cand;
  logic [SELW-1:0] pick;
  logic            found;
  logic [SW:0]     need;
  logic            fit;
  logic [7:0]      last;

  always_comb begin
    for (int i = 0; i < NBUF; i++)
      cand[i] = pend[i] && cfp_active && (slot[i] == cur_slot) &&
                ((st == E_IDLE) || ((st == E_WAIT) && (sel == SELW'(i))));
    found = 1'b0;
    pick  = '0;
    for (int i = NBUF - 1; i >= 0; i--)
      if (cand[i]) begin
        found = 1'b1;
        pick  = SELW'(i);
      end
  end

  assign need = {{(SW-8){1'b0}}, len_b[pick], 1'b0} + (SW+1)'(FIT_OVH);
  assign fit  = need <= {1'b0, slot_left};
  assign last = len_b[sel] + 8'd1;

  assign tx_start = (st == E_START);
  assign tx_valid = (st == E_SEND);
  assign tx_end   = (st == E_END);
  assign tx_data  = rd_byte;
  assign done_v   = (st == E_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= E_IDLE; sel <= '0; rd_idx <= '0; cnt <= '0; done_used <= '0;
      done_ok <= 1'b0; done_fnt <= 1'b0; done_cca <= 1'b0;
    end else begin
      case (st)
        E_IDLE, E_WAIT: if (found) begin
          sel <= pick;
          if (st == E_IDLE) done_used <= '0;
          done_ok <= 1'b0; done_fnt <= 1'b0; done_cca <= 1'b0;
          if (!fit) begin
            done_fnt <= 1'b1; st <= E_DONE;
          end else if (chan_busy) begin
            done_cca <= 1'b1; st <= E_DONE;
          end else begin
            rd_idx <= 8'd2; st <= E_START;
          end
        end
        E_START: st <= (len_b[sel] == 8'd0) ? E_END : E_SEND;
        E_SEND: if (tx_ready) begin
          if (rd_idx == last) st <= E_END;
          else rd_idx <= rd_idx + 8'd1;
        end
        E_END: begin
          cnt <= '0;
          if (ackreq[sel]) st <= E_ACKW;
          else begin done_ok <= 1'b1; st <= E_DONE; end
        end
        E_ACKW: if (ack_rx) begin
          done_ok <= 1'b1; st <= E_DONE;
        end else if (cnt == CW'(ACK_TO - 1)) begin
          if (done_used < rlim[sel]) begin
            done_used <= done_used + 2'd1; st <= E_WAIT;
          end else st <= E_DONE;
        end else cnt <= cnt + 1'b1;
        E_DONE: st <= E_IDLE;
        default: st <= E_IDLE;
      endcase
    end
  end

  // R11: stalled byte is held
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));
  // R4: a frame starts only after a cycle in its own slot of the free period
  p_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> $past(cfp_active) && ($past(cur_slot) == slot[sel]));
  // R7: retries used never exceed the limit
  p_retry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st != E_IDLE) |-> (done_used <= rlim[sel]));
  // R1: strobes and bytes never overlap
  p_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({tx_start, tx_valid, tx_end}) <= 1);
endmodule

// File: rtl/gts_tx_ctrl.sv
module gts_tx_ctrl
  import gts_pkg::*;
#(
  parameter int BUF_DEPTH = 128,
  parameter int ACK_TO    = 54,
  parameter int FIT_OVH   = 12,
  parameter int SLOT_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [AW-1:0]     host_waddr,
  input  logic [7:0]        host_wdata,
  input  logic [AW-1:0]     host_raddr,
  output logic [7:0]        host_rdata,
  output logic              irq,
  input  logic              cfp_active,
  input  logic [2:0]        cur_slot,
  input  logic [SLOT_W-1:0] slot_left,
  input  logic              chan_busy,
  input  logic              ack_rx,
  output logic              tx_start,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_end
);
  localparam int OW = $clog2(BUF_DEPTH);

  logic [NBUF-1:0]          busy;
  ctl_t [NBUF-1:0]          ctl;
  logic [NBUF-1:0][7:0]     len_b, eng_b, host_b;
  logic [NBUF-1:0][2:0]     slot;
  logic [NBUF-1:0]          ackreq;
  logic [NBUF-1:0][1:0]     rlim;
  logic [7:0]               rd_idx;
  logic [SELW-1:0]          sel;
  logic                     done_v, done_ok, done_fnt, done_cca;
  logic [1:0]               done_used;
  logic [7:0]               stat_q, irq_q;

  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    localparam int BASE = BUF_BASE + g * BUF_DEPTH;
    logic hit_w, c_we;
    assign hit_w = host_we && (int'(host_waddr) >= BASE) && (int'(host_waddr) < BASE + BUF_DEPTH);
    assign c_we  = host_we && (int'(host_waddr) == CTL_ADDR + g);
    assign slot[g]   = ctl[g].slot;
    assign ackreq[g] = ctl[g].ackreq;
    assign rlim[g]   = ctl[g].retry;

    gts_txbuf #(.DEPTH(BUF_DEPTH)) i_buf (
      .clk, .rst_n,
      .mem_we(hit_w), .mem_off(host_waddr[OW-1:0]), .wdata(host_wdata),
      .ctl_we(c_we), .eng_off(rd_idx[OW-1:0]), .eng_byte(eng_b[g]),
      .host_off(host_raddr[OW-1:0]), .host_byte(host_b[g]),
      .len_byte(len_b[g]), .ctl(ctl[g]), .busy(busy[g]),
      .done(done_v && (sel == SELW'(g))), .done_retry(done_used)
    );
  end

  gts_engine #(.SW(SLOT_W), .ACK_TO(ACK_TO), .FIT_OVH(FIT_OVH)) i_eng (
    .clk, .rst_n, .pend(busy), .slot, .ackreq, .rlim, .len_b,
    .rd_byte(eng_b[sel]), .rd_idx, .sel,
    .cfp_active, .cur_slot, .slot_left, .chan_busy, .ack_rx,
    .tx_start, .tx_valid, .tx_ready, .tx_data, .tx_end,
    .done_v, .done_ok, .done_fnt, .done_cca, .done_used
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      irq_q  <= '0;
    end else begin
      if (host_we && (int'(host_waddr) == IRQ_ADDR))
        irq_q <= irq_q & ~(host_wdata & 8'h06);
      if (done_v) begin
        stat_q[int'(sel) + 1] <= done_ok;
        stat_q[int'(sel) + 3] <= done_fnt;
        stat_q[5]             <= done_cca;
        irq_q[int'(sel) + 1]  <= 1'b1;
      end
    end
  end

  assign irq = |irq_q;

  always_comb begin
    host_rdata = '0;
    if (int'(host_raddr) == STAT_ADDR) host_rdata = stat_q;
    if (int'(host_raddr) == IRQ_ADDR)  host_rdata = irq_q;
    for (int i = 0; i < NBUF; i++) begin
      if (int'(host_raddr) == CTL_ADDR + i) host_rdata = ctl[i];
      if ((int'(host_raddr) >= BUF_BASE + i * BUF_DEPTH) &&
          (int'(host_raddr) < BUF_BASE + (i + 1) * BUF_DEPTH))
        host_rdata = host_b[i];
    end
  end

  // R8: every completion raises the interrupt
  p_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_v |=> irq);
endmodule

// File: tb/test_gts_tx_ctrl.sv
module test_gts_tx_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_we = 1'b0;
  logic [8:0] host_waddr = '0, host_raddr = '0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic irq, cfp_active = 1'b1, chan_busy = 1'b0, ack_rx = 1'b0;
  logic [2:0] cur_slot = 3'd7;
  logic [15:0] slot_left = 16'd1000;
  logic tx_start, tx_valid, tx_ready = 1'b1, tx_end;
  logic [7:0] tx_data;

  always #4 clk = ~clk;

  gts_tx_ctrl i_gts_tx_ctrl (.*);

  int n_run = 0, n_fail = 0, cyc = 0, starts = 0, ends = 0;
  int ack_skip = 0, ack_hold = 0;
  bit ack_en = 0, bp_on = 0;
  logic [7:0] exp_q[$];

  task automatic chk(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: drives ready/ack, pops scoreboard on each handshake
  always @(negedge clk) begin
    cyc++;
    tx_ready = bp_on ? (cyc % 3 != 1) : 1'b1;
    if (ack_hold > 0) begin
      ack_hold--;
      if (ack_hold == 0) ack_rx = 1'b0;
    end
    if (tx_start) starts++;
    if (tx_end) begin
      ends++;
      if (ack_en) begin
        if (ack_skip > 0) ack_skip--;
        else begin ack_rx = 1'b1; ack_hold = 2; end
      end
    end
    if (tx_valid && tx_ready) begin
      if (exp_q.size() == 0) chk(0, "R1 unexpected byte", tx_data, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(tx_data == e, "R1/R9 byte", tx_data, e);
      end
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    host_we = 1'b1; host_waddr = 9'(a); host_wdata = 8'(d);
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk);
    host_raddr = 9'(a);
    #1 d = int'(host_rdata);
  endtask

  task automatic load(int b, int m, int n, int seed);
    int base = 'h100 + b * 128;
    wr(base, m);
    wr(base + 1, m + n);
    for (int k = 0; k < m + n; k++) wr(base + 2 + k, (seed + k) & 255);
  endtask

  task automatic expect_frame(int len, int seed);
    for (int k = 0; k < len; k++) exp_q.push_back(8'((seed + k) & 255));
  endtask

  task automatic wait_irq(int mask, string req);
    int v = 0;
    for (int t = 0; t < 20000; t++) begin
      rd('h021, v);
      if ((v & mask) == mask) break;
    end
    chk((v & mask) == mask, req, v, mask);
  endtask

  task automatic clr_irq();
    int v;
    wr('h021, 'h06);
    rd('h021, v);
    chk(v == 0 && irq == 1'b0, "R8 irq clear", v, 0);
  endtask

  initial begin
    int v, s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    rd('h020, v); chk(v == 0, "R8 reset status", v, 0);
    chk(irq == 0 && tx_valid == 0, "R8 reset outputs", {irq, tx_valid}, 0);

    // basic send on buffer A, slot 2, back-pressure on
    bp_on = 1;
    load(0, 3, 5, 'h40);
    wr('h010, 'h11);
    rd('h010, v); chk(v == 'h10, "R3 launch bit cleared R2", v, 'h10);
    s0 = starts;
    repeat (30) @(negedge clk);
    chk(starts == s0 && !tx_valid, "R4 no send before slot", starts - s0, 0);
    wr('h102, 'hEE);
    rd('h102, v); chk(v == 'h40, "R10 memory write ignored", v, 'h40);
    wr('h010, 'hFF);
    rd('h010, v); chk(v == 'h10, "R10 control write ignored", v, 'h10);
    expect_frame(8, 'h40);
    cur_slot = 3'd2;
    wait_irq('h02, "R8 irq A");
    cur_slot = 3'd7;
    rd('h020, v); chk(v[1] == 1'b1, "R8 success A", v, 'h02);
    chk(starts == s0 + 1 && ends == s0 + 1, "R1 strobes", starts - s0, 1);
    chk(exp_q.size() == 0, "R1 all bytes sent R11", exp_q.size(), 0);
    clr_irq();

    // ack with one missed ack, buffer B slot 4 limit 2
    ack_en = 1; ack_skip = 1;
    load(1, 2, 4, 'h80);
    expect_frame(6, 'h80); expect_frame(6, 'h80);
    s0 = starts;
    wr('h011, 'hA5);
    cur_slot = 3'd4;
    wait_irq('h04, "R7 irq B");
    cur_slot = 3'd7;
    rd('h020, v); chk(v[2] == 1'b1, "R7 success after retry", v, 'h04);
    rd('h011, v); chk(v[7:6] == 2'd1, "R7 retries used", v[7:6], 1);
    chk(starts == s0 + 2, "R7 two attempts", starts - s0, 2);
    clr_irq();

    // retries exhausted, buffer A slot 1 limit 1
    ack_en = 0;
    expect_frame(8, 'h40); expect_frame(8, 'h40);
    s0 = starts;
    wr('h010, 'h4D);
    cur_slot = 3'd1;
    wait_irq('h02, "R7 irq fail");
    cur_slot = 3'd7;
    rd('h020, v); chk(v[1] == 1'b0, "R7 failure flagged", v[1], 0);
    rd('h010, v); chk(v[7:6] == 2'd1, "R7 retries exhausted", v[7:6], 1);
    chk(starts == s0 + 2 && exp_q.size() == 0, "R7 attempts", starts - s0, 2);
    clr_irq();
    bp_on = 0;

    // no time left: need 2*50+12=112, left 111
    load(0, 10, 40, 'h10);
    slot_left = 16'd111;
    s0 = starts;
    wr('h010, 'h19);
    cur_slot = 3'd3;
    wait_irq('h02, "R5 irq A");
    cur_slot = 3'd7;
    rd('h020, v); chk(v[3] == 1'b1 && v[1] == 1'b0, "R5 no-time A", v, 'h08);
    chk(starts == s0, "R5 nothing sent", starts - s0, 0);
    clr_irq();
    load(1, 10, 40, 'h20);
    wr('h011, 'h19);
    cur_slot = 3'd3;
    wait_irq('h04, "R5 irq B");
    cur_slot = 3'd7;
    rd('h020, v); chk(v[4] == 1'b1 && v[2] == 1'b0, "R5 no-time B", v, 'h10);
    clr_irq();
    // exact fit sends
    slot_left = 16'd112;
    expect_frame(50, 'h10);
    wr('h010, 'h19);
    cur_slot = 3'd3;
    wait_irq('h02, "R5 irq fit");
    cur_slot = 3'd7;
    rd('h020, v); chk(v[1] == 1'b1 && v[3] == 1'b0, "R5 exact fit", v, 'h02);
    chk(exp_q.size() == 0, "R5 bytes sent", exp_q.size(), 0);
    clr_irq();
    slot_left = 16'd1000;

    // channel busy
    load(0, 3, 5, 'h60);
    chan_busy = 1'b1;
    s0 = starts;
    wr('h010, 'h29);
    cur_slot = 3'd5;
    wait_irq('h02, "R6 irq");
    cur_slot = 3'd7; chan_busy = 1'b0;
    rd('h020, v); chk(v[5] == 1'b1 && v[1] == 1'b0, "R6 busy flag", v, 'h20);
    chk(starts == s0, "R6 nothing sent", starts - s0, 0);
    clr_irq();

    // priority: both in slot 6
    load(1, 2, 4, 'hC0);
    expect_frame(8, 'h60); expect_frame(6, 'hC0);
    wr('h011, 'h31);
    wr('h010, 'h31);
    cur_slot = 3'd6;
    wait_irq('h06, "R9 both done");
    cur_slot = 3'd7;
    rd('h020, v); chk(v[2:1] == 2'b11, "R9 both succeed", v, 'h06);
    chk(exp_q.size() == 0, "R9 order complete", exp_q.size(), 0);
    clr_irq();

    finish_run();
  end
endmodule